// File: doc/BRIEF.md
# Byte-Register I2C Target with Pointer Auto-Increment

This block lets an external I2C controller reach a small byte-wide register bank. It runs only as a target and supports standard and fast mode timing. A free-running local clock samples SCL and SDA, so the block keeps working when the surrounding video datapath has no clock. Each line passes through a two-stage synchronizer and then a stability filter. Start and stop conditions and bit edges are taken from the filtered lines.

The block answers to two 8-bit bus addresses, one for writes and one for reads. The `dev_sel` strap sets bit 1 of both. A write transfer sends the address byte, then one byte that loads the register pointer, then any number of data bytes. A read transfer returns bytes from the current pointer value. The pointer advances by one after every data byte in either direction, so a burst touches consecutive registers. The last few registers are read-only constants. Writes to them are acknowledged but change nothing.

Top module: `i2c_regmap_slave`

## Requirements
- R1: With `dev_sel`=0 the block answers to address byte 0x40 (write) and 0x41 (read). With `dev_sel`=1 it answers to 0x42 and 0x43. Bit 1 of the address byte must equal `dev_sel`, and bit 0 selects read (1) or write (0).
- R2: The block pulls SDA low during the ninth clock after a matching address byte, after the pointer byte and after every data byte it receives.
- R3: When the address byte matches neither address, the block gives no acknowledge, ignores every further byte of that transfer and changes no register.
- R4: In a write transfer the first byte after the address loads the pointer. Each following data byte is stored at the pointer, and the pointer then advances by one.
- R5: A read transfer returns the register at the current pointer, MSB first, and the pointer advances by one after each byte sent. With no new pointer byte, a read continues where the previous transfer left off.
- R6: A controller acknowledge after a read byte makes the block send the next register. A controller non-acknowledge makes it release SDA and ignore the bus until the next start or stop.
- R7: Registers 12 to 15 are read-only and read as 0xA0 OR their index (0xAC to 0xAF). Writes to them are acknowledged and leave them unchanged. Registers 0 to 11 are read/write.
- R8: A start, a repeated start or a stop at any point returns the block to matching an address byte. A repeated start after a pointer byte lets a read begin at that pointer.
- R9: Pulses on SCL or SDA that last fewer than 3 local clock cycles are ignored and do not disturb a transfer in progress.
- R10: During and right after reset the block does not pull SDA low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_sel | input | 1 | Address strap; sets bit 1 of the address byte |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_drive_low | output | 1 | High pulls SDA low through an open-drain driver |

## Verification
The assertions assume the bus controller follows the protocol. SDA changes only while SCL is low, except to form a start or a stop. The controller never forms a start or stop while the block itself holds SDA low. `dev_sel` changes only while the bus is idle. The bench controller obeys these rules: it moves SDA a quarter bit-period after SCL falls and lets go of SDA in every acknowledge slot and every read bit. Glitches are injected only as deliberate two-sample pulses, placed where they would otherwise look like a start or an extra clock edge.

// File: rtl/i2c_rm_pkg.sv
package i2c_rm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_SKIP
  } rm_state_t;
endpackage

// File: rtl/i2c_rm_filter.sv
// Two-flop synchronizer followed by a stability filter: the output follows
// the input only after FILT consecutive samples disagree with it.
module i2c_rm_filter #(
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_out
);
  localparam int CW = $clog2(FILT + 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync     <= 2'b11;
      cnt      <= '0;
      line_out <= 1'b1;
    end else begin
      sync <= {sync[0], line_in};
      if (sync[1] == line_out) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT - 1)) begin
        line_out <= sync[1];
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_rm_fsm.sv
// Bit and byte engine: start/stop detection, address match, pointer and
// data phases, acknowledge and read-data driving on SDA.
module i2c_rm_fsm
  import i2c_rm_pkg::*;
#(
  parameter logic [6:0] DEV_ID7 = 7'h20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic       dev_sel,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       wr_en,
  output logic       sda_low,
  output logic       start_det
);
  rm_state_t  state;
  logic       scl_d, sda_d;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txreg;
  logic       is_read, mack;
  logic       scl_rise, scl_fall, stop_det, addr_hit, byte_end;

  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign start_det = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;
  assign addr_hit  = (shreg[7:1] == {DEV_ID7[6:1], dev_sel});
  assign byte_end  = scl_fall && (bitcnt == 4'd8);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
      bitcnt  <= '0;
      shreg   <= '0;
      txreg   <= '0;
      is_read <= 1'b0;
      mack    <= 1'b0;
      ptr     <= '0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_en   <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bitcnt  <= '0;
        sda_low <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        sda_low <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_f};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_end) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  sda_low <= 1'b1;
                  is_read <= shreg[0];
                  state   <= ST_ADDR_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_SUB) begin
                ptr     <= shreg;
                sda_low <= 1'b1;
                state   <= ST_SUB_ACK;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= ptr + 8'd1;
                sda_low <= 1'b1;
                state   <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              if (state == ST_ADDR_ACK && is_read) begin
                txreg   <= rd_data;
                sda_low <= ~rd_data[7];
                bitcnt  <= '0;
                state   <= ST_RDATA;
              end else begin
                sda_low <= 1'b0;
                state   <= (state == ST_ADDR_ACK) ? ST_SUB : ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_end) begin
              sda_low <= 1'b0;
              ptr     <= ptr + 8'd1;
              state   <= ST_RDATA_ACK;
            end else if (scl_fall) begin
              txreg   <= {txreg[6:0], 1'b0};
              sda_low <= ~txreg[6];
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_f;
            end else if (scl_fall) begin
              if (mack) begin
                txreg   <= rd_data;
                sda_low <= ~rd_data[7];
                bitcnt  <= '0;
                state   <= ST_RDATA;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_rm_regbank.sv
// Byte register bank: RW entries in an inferable RAM array, RO entries
// computed from their index, registered read port.
module i2c_rm_regbank #(
  parameter int         NUM_REGS = 16,
  parameter int         RO_FIRST = 12,
  parameter logic [7:0] RO_TAG   = 8'hA0
) (
  input  logic       clk,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam int         IW     = (RO_FIRST > 1) ? $clog2(RO_FIRST) : 1;
  localparam logic [7:0] RO_LIM = 8'(RO_FIRST);
  localparam logic [7:0] N_LIM  = 8'(NUM_REGS);

  logic [7:0] mem [RO_FIRST];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < RO_LIM)) begin
      mem[wr_addr[IW-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_addr < RO_LIM) begin
      rd_data <= mem[rd_addr[IW-1:0]];
    end else if (rd_addr < N_LIM) begin
      rd_data <= RO_TAG | rd_addr;
    end else begin
      rd_data <= 8'h00;
    end
  end
endmodule

// File: rtl/i2c_regmap_slave.sv
module i2c_regmap_slave #(
  parameter int         FILT     = 3,
  parameter logic [6:0] DEV_ID7  = 7'h20,
  parameter int         NUM_REGS = 16,
  parameter int         RO_FIRST = 12,
  parameter logic [7:0] RO_TAG   = 8'hA0
) (
  input  logic clk,
  input  logic rst,
  input  logic dev_sel,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_drive_low
);
  logic       scl_f, sda_f, start_det, wr_en;
  logic [7:0] ptr, wr_addr, wr_data, rd_data;

  i2c_rm_filter #(.FILT(FILT)) u_scl_flt (
    .clk(clk), .rst(rst), .line_in(scl_in), .line_out(scl_f)
  );

  i2c_rm_filter #(.FILT(FILT)) u_sda_flt (
    .clk(clk), .rst(rst), .line_in(sda_in), .line_out(sda_f)
  );

  i2c_rm_fsm #(.DEV_ID7(DEV_ID7)) u_fsm (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f), .dev_sel(dev_sel),
    .rd_data(rd_data), .ptr(ptr), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_en(wr_en), .sda_low(sda_drive_low), .start_det(start_det)
  );

  i2c_rm_regbank #(.NUM_REGS(NUM_REGS), .RO_FIRST(RO_FIRST), .RO_TAG(RO_TAG)) u_regs (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data)
  );
endmodule

// File: rtl/i2c_regmap_slave_chk.sv
module i2c_regmap_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_f,
  input logic       sda_drive_low,
  input logic       start_det,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] ptr
);
  AST_RESET_RELEASE: assert property (@(posedge clk) rst |=> !sda_drive_low); // R10

  AST_DRIVE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low) |-> !$past(scl_f)); // R2

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R4

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (ptr == 8'(wr_addr + 8'd1))); // R4

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_drive_low); // R8
endmodule

bind i2c_regmap_slave i2c_regmap_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_f(scl_f), .sda_drive_low(sda_drive_low),
  .start_det(start_det), .wr_en(wr_en), .wr_addr(wr_addr), .ptr(ptr)
);

// File: tb/i2c_regmap_slave_test.sv
`timescale 1ns/1ps
module i2c_regmap_slave_test;
  localparam int Q = 500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dev_sel = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, sda_glt = 1'b0;
  logic sda_drive_low;
  logic sda_line;

  int nchk = 0, nfail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  assign sda_line = sda_m & ~sda_drive_low & ~sda_glt;

  always #10 clk = ~clk;

  i2c_regmap_slave uut (
    .clk(clk), .rst(rst), .dev_sel(dev_sel),
    .scl_in(scl_m), .sda_in(sda_line), .sda_drive_low(sda_drive_low)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each received read byte with the next expected one
  always @(negedge clk) begin
    if (got_q.size() > 0) begin
      logic [7:0] g;
      g = got_q.pop_front();
      if (exp_q.size() > 0) chk(tag_q.pop_front(), g, exp_q.pop_front());
      else chk("SCOREBOARD unexpected byte", g, 0);
    end
  end

  task automatic expect_rd(input string req, input logic [7:0] v);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  // kind: 0 plain, 1 short SDA pulse during SCL high, 2 short SCL pulse during SCL low
  task automatic bit_out(input logic b, input int kind = 0);
    sda_m = b;
    if (kind == 2) begin
      #(Q/2); scl_m = 1'b1; #40; scl_m = 1'b0; #(Q/2 - 40);
    end else begin
      #Q;
    end
    scl_m = 1'b1;
    if (kind == 1) begin
      #Q; sda_glt = 1'b1; #40; sda_glt = 1'b0; #(Q - 40);
    end else begin
      #(2*Q);
    end
    scl_m = 1'b0; #Q;
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; b = sda_line; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked, input int gbit = -1, input int kind = 0);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i], (i == gbit) ? kind : 0);
    bit_in(a);
    acked = ~a;
  endtask

  task automatic send_chk(input string req, input logic [7:0] v, input logic exp_ack);
    logic a;
    send_byte(v, a);
    chk(req, a, exp_ack);
  endtask

  task automatic recv_byte(input logic give_ack);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    got_q.push_back(v);
    bit_out(~give_ack);
  endtask

  initial begin : watchdog
    #(150000 * 20);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic a;
    #3;
    repeat (3) @(posedge clk);
    #3;
    chk("R10 drive during reset", sda_drive_low, 0);
    repeat (3) @(posedge clk);
    #3;
    rst = 1'b0;
    repeat (2) @(posedge clk);
    #3;
    chk("R10 drive after reset", sda_drive_low, 0);

    // R4/R2: burst write 11,22,33,44 to regs 3..6
    bus_start();
    send_chk("R1 write addr 0x40 sel0", 8'h40, 1);
    send_chk("R2 pointer byte ack", 8'h03, 1);
    send_chk("R2 data ack", 8'h11, 1);
    send_chk("R4 data ack", 8'h22, 1);
    send_chk("R4 data ack", 8'h33, 1);
    send_chk("R4 data ack", 8'h44, 1);
    bus_stop();

    // R8: pointer byte, repeated start, read burst
    bus_start();
    send_chk("R1 write addr", 8'h40, 1);
    send_chk("R2 pointer ack", 8'h03, 1);
    bus_start();
    send_chk("R8 read addr after repeated start", 8'h41, 1);
    expect_rd("R5 read reg3", 8'h11);
    expect_rd("R6 ack continues reg4", 8'h22);
    expect_rd("R4 auto-inc reg5", 8'h33);
    recv_byte(1'b1);
    recv_byte(1'b1);
    recv_byte(1'b0);
    chk("R6 released after nack", sda_drive_low, 0);
    bus_stop();

    // R5: read continues at pointer 6
    bus_start();
    send_chk("R1 read addr 0x41", 8'h41, 1);
    expect_rd("R5 read resumes at pointer reg6", 8'h44);
    recv_byte(1'b0);
    bus_stop();

    // R7: write across RW/RO boundary
    bus_start();
    send_chk("R1 write addr", 8'h40, 1);
    send_chk("R2 pointer ack", 8'h0B, 1);
    send_chk("R7 rw reg11 ack", 8'h55, 1);
    send_chk("R7 ro reg12 write ack", 8'h99, 1);
    bus_stop();
    bus_start();
    send_chk("R1 write addr", 8'h40, 1);
    send_chk("R2 pointer ack", 8'h0B, 1);
    bus_start();
    send_chk("R1 read addr", 8'h41, 1);
    expect_rd("R7 reg11 written", 8'h55);
    expect_rd("R7 reg12 unchanged", 8'hAC);
    expect_rd("R7 reg13 constant", 8'hAD);
    recv_byte(1'b1);
    recv_byte(1'b1);
    recv_byte(1'b0);
    bus_stop();

    // R3: foreign address, rest of transfer ignored
    bus_start();
    send_chk("R3 foreign addr nack", 8'h44, 0);
    send_chk("R3 ignored byte nack", 8'h03, 0);
    send_chk("R3 ignored byte nack", 8'h77, 0);
    bus_stop();
    bus_start();
    send_chk("R1 0x42 nack when sel0", 8'h42, 0);
    bus_stop();
    bus_start();
    send_chk("R1 write addr", 8'h40, 1);
    send_chk("R2 pointer ack", 8'h03, 1);
    bus_start();
    send_chk("R1 read addr", 8'h41, 1);
    expect_rd("R3 reg3 unchanged", 8'h11);
    recv_byte(1'b0);
    bus_stop();

    // R1: strap high
    dev_sel = 1'b1;
    #Q;
    bus_start();
    send_chk("R1 0x40 nack when sel1", 8'h40, 0);
    bus_stop();
    bus_start();
    send_chk("R1 write addr 0x42", 8'h42, 1);
    send_chk("R2 pointer ack", 8'h00, 1);
    send_chk("R2 data ack", 8'h5A, 1);
    bus_start();
    send_chk("R1 write addr 0x42", 8'h42, 1);
    send_chk("R2 pointer ack", 8'h00, 1);
    bus_start();
    send_chk("R1 read addr 0x43", 8'h43, 1);
    expect_rd("R1 readback with sel1", 8'h5A);
    recv_byte(1'b0);
    bus_stop();

    // R8: stop mid-byte, then fresh address
    bus_start();
    send_chk("R1 write addr", 8'h42, 1);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    bus_stop();
    bus_start();
    send_chk("R8 address match after stop mid-byte", 8'h42, 1);
    bus_stop();

    // R9: short pulses on SDA and SCL during data bytes
    bus_start();
    send_chk("R1 write addr", 8'h42, 1);
    send_chk("R2 pointer ack", 8'h02, 1);
    send_byte(8'h3C, a, 5, 1);
    chk("R9 ack despite SDA pulse", a, 1);
    send_byte(8'hC3, a, 3, 2);
    chk("R9 ack despite SCL pulse", a, 1);
    bus_stop();
    bus_start();
    send_chk("R1 write addr", 8'h42, 1);
    send_chk("R2 pointer ack", 8'h02, 1);
    bus_start();
    send_chk("R1 read addr", 8'h43, 1);
    expect_rd("R9 reg2 intact", 8'h3C);
    expect_rd("R9 reg3 intact", 8'hC3);
    recv_byte(1'b1);
    recv_byte(1'b0);
    bus_stop();

    repeat (20) @(posedge clk);
    #3;
    chk("SCOREBOARD pending expected R5", exp_q.size(), 0);
    chk("SCOREBOARD pending received R5", got_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule